// File: doc/BRIEF.md
# DAC Code Gain and Offset Corrector

This block turns a signed DAC data code into a corrected code ready for a DAC latch. It scales the data by an unsigned gain code and then adds a signed offset code. The result is clipped to the signed range of the code width rather than wrapping. Three write strobes share one value bus and load the data, gain and offset registers.

Any write starts a new sequential recalculation. The multiply is done as shift-and-add, one gain bit per cycle. While it runs, a busy flag is high. An active-low load strobe decides when a finished result moves into the output latch. If the strobe is low at completion, the result goes out at once. If the strobe was seen low at any point after the write, the result also goes out at completion. If the strobe stays high past completion, the result is held and goes out on the strobe's next falling edge.

The block resets to a zero output code with the output drive disabled. The drive enable goes high at the first transfer into the latch and stays high after that. The load strobe is taken to be synchronous to `clk`.

Top module: `dac_corrector`

## Requirements
- R1: The data code D and the offset code O are W-bit two's complement values. The gain code G is a W-bit unsigned value. The corrected code is floor(D*(G+1)/2^W) + O, with the floor taken toward negative infinity before O is added.
- R2: An all-ones gain code (0x3FFFF at W=18) gives unity gain. The gain code 0 gives a gain of 1/2^W. The gain code 2^(W-1)-1 gives one half.
- R3: A corrected sum above 2^(W-1)-1 clips to 2^(W-1)-1 (0x1FFFF at W=18). A sum below -2^(W-1) clips to -2^(W-1) (0x20000 at W=18).
- R4: `busy` is high in the cycle after a write strobe. With no further writes, it stays high for exactly W+2 cycles (20 cycles at W=18) and then falls.
- R5: A write while `busy` is high restarts the calculation with the newest register contents. `busy` then stays high for W+2 cycles after that last write, and only the final result ever reaches `out_code`.
- R6: If `ldac_n` is low in the first cycle in which `busy` is low, `out_code` takes the new result one cycle later. It does not change before that.
- R7: If `ldac_n` was sampled low at any clock after a write, `out_code` updates at completion, even if `ldac_n` has gone high again by then.
- R8: If `ldac_n` stays high from the write until after completion, `out_code` keeps its old value. It takes the new result in the cycle after the first clock that samples `ldac_n` low following a high sample.
- R9: During reset, `out_code` is 0, `out_en` is 0 and `busy` is 0. The registers reset to data 0, gain all-ones and offset 0.
- R10: `out_en` stays 0 until the first transfer into the output latch. It is 1 from then until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_data | input | 1 | Load `wr_value` into the data register |
| wr_gain | input | 1 | Load `wr_value` into the gain register |
| wr_offset | input | 1 | Load `wr_value` into the offset register |
| wr_value | input | W | Value written by the strobes |
| ldac_n | input | 1 | Active-low load strobe for the output latch |
| busy | output | 1 | Recalculation in progress |
| out_code | output | W | Latched corrected code |
| out_en | output | 1 | Output drive enable (0 = high impedance) |

## Verification
Two events can land in the same cycle. In the first, a register write arrives in the final cycle of a recalculation. The write must win: the stale result is dropped and a full new busy window follows. The bench provokes this by rewriting during `busy` and then counting busy cycles from the last write. In the second, a load-strobe pulse arrives while the calculation is still running. The bench pulses `ldac_n` low mid-calculation and checks that the latch stays unchanged until completion and then updates in the expected cycle. The arithmetic is swept over every data and gain pair at a 5-bit width, with the offset varied across that sweep, and each result is compared with a floor-and-clip model computed in the bench.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
  localparam int unsigned N_COEF   = 3;
  localparam int unsigned IDX_DATA = 0;
  localparam int unsigned IDX_GAIN = 1;
  localparam int unsigned IDX_OFF  = 2;

  typedef enum logic {MUL_IDLE, MUL_RUN} mul_state_t;
endpackage

// File: rtl/dacc_coef_regs.sv
module dacc_coef_regs #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   stb,
  input  logic [W-1:0] wr_value,
  output logic [W-1:0] data_q,
  output logic [W-1:0] gain_q,
  output logic [W-1:0] off_q,
  output logic         start_q
);
  import dacc_pkg::*;

  logic [W-1:0] regs [N_COEF];

  for (genvar i = 0; i < N_COEF; i++) begin : g_reg
    localparam logic [W-1:0] RV = (i == IDX_GAIN) ? {W{1'b1}} : '0;
    always_ff @(posedge clk) begin
      if (rst)         regs[i] <= RV;
      else if (stb[i]) regs[i] <= wr_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= |stb;
  end

  assign data_q = regs[IDX_DATA];
  assign gain_q = regs[IDX_GAIN];
  assign off_q  = regs[IDX_OFF];
endmodule

// File: rtl/dacc_mul.sv
module dacc_mul #(
  parameter int W = 18,
  localparam int PW = 2*W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  data,
  input  logic [W-1:0]  gain,
  output logic [PW-1:0] product,
  output logic          done
);
  import dacc_pkg::*;

  localparam int CW = $clog2(W + 1);

  mul_state_t    state;
  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;
  logic [CW-1:0] cnt;
  logic [PW-1:0] data_x;

  assign data_x = {{(PW-W){data[W-1]}}, data};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= MUL_IDLE;
      done    <= 1'b0;
      product <= '0;
      mcand   <= '0;
      mplier  <= '0;
      cnt     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        product <= data_x;
        mcand   <= data_x;
        mplier  <= gain;
        cnt     <= '0;
        state   <= MUL_RUN;
      end else if (state == MUL_RUN) begin
        if (mplier[0]) product <= product + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          state <= MUL_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dacc_sat.sv
module dacc_sat #(
  parameter int W = 18,
  localparam int PW = 2*W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mul_done,
  input  logic          abort,
  input  logic [PW-1:0] product,
  input  logic [W-1:0]  offset,
  output logic          fin,
  output logic [W-1:0]  corr,
  output logic          calc_done
);
  localparam logic signed [PW-1:0] MAXV = PW'(2**(W-1) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - 1;

  logic signed [PW-1:0] sum_c;
  logic [W-1:0]         clip_c;

  assign sum_c = ($signed(product) >>> W) + $signed({{(PW-W){offset[W-1]}}, offset});
  assign fin   = mul_done & ~abort;

  always_comb begin
    if (sum_c > MAXV)      clip_c = MAXV[W-1:0];
    else if (sum_c < MINV) clip_c = MINV[W-1:0];
    else                   clip_c = sum_c[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      corr      <= '0;
      calc_done <= 1'b0;
    end else begin
      calc_done <= fin;
      if (fin) corr <= clip_c;
    end
  end
endmodule

// File: rtl/dacc_ldac.sv
module dacc_ldac #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         any_wr,
  input  logic         calc_done,
  input  logic [W-1:0] corr,
  input  logic         ldac_n,
  output logic [W-1:0] out_code,
  output logic         out_en
);
  logic ldac_prev, low_seen, hold, xfer;

  assign xfer = (calc_done & (low_seen | ~ldac_n)) |
                (hold & ldac_prev & ~ldac_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      ldac_prev <= 1'b1;
      low_seen  <= 1'b0;
      hold      <= 1'b0;
      out_code  <= '0;
      out_en    <= 1'b0;
    end else begin
      ldac_prev <= ldac_n;
      low_seen  <= any_wr ? ~ldac_n : (low_seen | ~ldac_n);
      if (any_wr || xfer) hold <= 1'b0;
      else if (calc_done) hold <= 1'b1;
      if (xfer) begin
        out_code <= corr;
        out_en   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_corrector.sv
module dac_corrector #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_data,
  input  logic         wr_gain,
  input  logic         wr_offset,
  input  logic [W-1:0] wr_value,
  input  logic         ldac_n,
  output logic         busy,
  output logic [W-1:0] out_code,
  output logic         out_en
);
  localparam int PW = 2*W + 1;

  logic [2:0]    stb;
  logic          any_wr, start_q, mul_done, fin, calc_done;
  logic [W-1:0]  data_q, gain_q, off_q, corr;
  logic [PW-1:0] product;

  assign stb    = {wr_offset, wr_gain, wr_data};
  assign any_wr = |stb;

  dacc_coef_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .stb(stb), .wr_value(wr_value),
    .data_q(data_q), .gain_q(gain_q), .off_q(off_q), .start_q(start_q));

  dacc_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .start(start_q), .data(data_q), .gain(gain_q),
    .product(product), .done(mul_done));

  dacc_sat #(.W(W)) u_sat (
    .clk(clk), .rst(rst), .mul_done(mul_done), .abort(start_q | any_wr),
    .product(product), .offset(off_q), .fin(fin), .corr(corr),
    .calc_done(calc_done));

  dacc_ldac #(.W(W)) u_ldac (
    .clk(clk), .rst(rst), .any_wr(any_wr), .calc_done(calc_done),
    .corr(corr), .ldac_n(ldac_n), .out_code(out_code), .out_en(out_en));

  always_ff @(posedge clk) begin
    if (rst)         busy <= 1'b0;
    else if (any_wr) busy <= 1'b1;
    else if (fin)    busy <= 1'b0;
  end
endmodule

// File: rtl/dacc_checker.sv
module dacc_checker #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_data,
  input logic         wr_gain,
  input logic         wr_offset,
  input logic         busy,
  input logic [W-1:0] out_code,
  input logic         out_en
);
  localparam int BW = $clog2(W + 4) + 1;

  logic          any_wr;
  logic [BW-1:0] bcnt;

  assign any_wr = wr_data | wr_gain | wr_offset;

  always_ff @(posedge clk) begin
    if (rst || any_wr)                bcnt <= '0;
    else if (busy && bcnt < BW'(W+3)) bcnt <= bcnt + 1'b1;
  end

  // R4: busy rises only after a write strobe
  p_busy_after_write_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(any_wr));

  // R4: busy never lasts longer than W+2 cycles after the last write
  p_busy_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt <= BW'(W+1)));

  // R6: the latch never changes while a calculation was in flight
  p_out_quiet_busy_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_code) |-> !$past(busy));

  // R10: output enable never drops outside reset
  p_en_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !$fell(out_en));

  // R9: reset state
  p_reset_state_r9: assert property (@(posedge clk)
    rst |=> (out_code == '0 && !out_en && !busy));
endmodule

bind dac_corrector dacc_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .wr_data(wr_data), .wr_gain(wr_gain),
  .wr_offset(wr_offset), .busy(busy), .out_code(out_code), .out_en(out_en));

// File: tb/dac_corrector_test.sv
module dac_corrector_test;
  localparam int W = 5;
  localparam int HALF = 1 << (W-1);
  localparam int FULL = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_data = 0, wr_gain = 0, wr_offset = 0;
  logic [W-1:0] wr_value = '0;
  logic ldac_n = 1'b1;
  logic busy, out_en;
  logic [W-1:0] out_code;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dac_corrector #(.W(W)) uut (
    .clk(clk), .rst(rst), .wr_data(wr_data), .wr_gain(wr_gain),
    .wr_offset(wr_offset), .wr_value(wr_value), .ldac_n(ldac_n),
    .busy(busy), .out_code(out_code), .out_en(out_en));

  function automatic int sx(int c);
    return (c >= HALF) ? c - FULL : c;
  endfunction

  function automatic int model(int d, int g, int o);
    int p, q, s;
    p = sx(d) * (g + 1);
    q = p >>> W;
    s = q + sx(o);
    if (s > HALF - 1) s = HALF - 1;
    if (s < -HALF) s = -HALF;
    return s & (FULL - 1);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(int kind, int v);
    @(negedge clk);
    wr_value = W'(v);
    wr_data = (kind == 0); wr_gain = (kind == 1); wr_offset = (kind == 2);
    @(negedge clk);
    wr_data = 0; wr_gain = 0; wr_offset = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic calc(int d, int g, int o);
    wr(1, g);
    wr(2, o);
    wr(0, d);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check(out_code == 0, "R9 reset out_code", out_code, 0);
    check(out_en == 0, "R9 reset out_en", out_en, 0);
    check(busy == 0, "R9 reset busy", busy, 0);
    rst = 0;
    @(negedge clk);

    // R8/R10: ldac held high, default gain unity, offset zero
    wr(0, 5);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check(cnt == W + 2, "R4 busy length", cnt, W + 2);
    repeat (3) @(negedge clk);
    check(out_code == 0, "R8 held while ldac high", out_code, 0);
    check(out_en == 0, "R10 enable before transfer", out_en, 0);
    ldac_n = 0;
    @(negedge clk);
    check(out_code == 5, "R8 update on ldac fall / R9 default gain", out_code, 5);
    check(out_en == 1, "R10 enable after transfer", out_en, 1);

    // R6: exact update cycle with ldac low
    wr(2, 0);
    wr(1, FULL - 1);
    wr(0, 9);
    while (busy) @(negedge clk);
    check(out_code == 5, "R6 no early update", out_code, 5);
    @(negedge clk);
    check(out_code == 9, "R6 update one cycle after busy falls", out_code, 9);

    // R2 gain encodings
    calc(HALF, FULL - 1, 0);
    check(out_code == W'(HALF), "R2 unity gain negative full", out_code, HALF);
    calc(HALF - 1, 0, 0);
    check(out_code == 0, "R2 minimum gain", out_code, 0);
    calc(12, HALF - 1, 0);
    check(out_code == 6, "R2 half gain", out_code, 6);
    calc(FULL - 1, 0, 0);
    check(out_code == W'(FULL - 1), "R1 floor toward minus infinity", out_code, FULL - 1);

    // R3 saturation
    calc(HALF - 1, FULL - 1, HALF - 1);
    check(out_code == W'(HALF - 1), "R3 clip positive", out_code, HALF - 1);
    calc(HALF, FULL - 1, HALF);
    check(out_code == W'(HALF), "R3 clip negative", out_code, HALF);

    // R5 restart during busy
    wr(2, 0);
    wr(1, FULL - 1);
    wr(0, 3);
    repeat (3) @(negedge clk);
    wr(0, 11);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check(cnt == W + 2, "R5 busy after last write", cnt, W + 2);
    @(negedge clk);
    check(out_code == 11, "R5 latest value wins", out_code, 11);

    // R5 write landing in the final busy cycle
    wr(0, 2);
    repeat (W) @(negedge clk);
    wr(0, 13);
    wait_idle();
    check(out_code == 13, "R5 write in completion cycle", out_code, 13);

    // R7 ldac pulse during calculation
    ldac_n = 1;
    wr(0, 7);
    @(negedge clk);
    ldac_n = 0;
    @(negedge clk);
    ldac_n = 1;
    check(out_code == 13, "R7 no update while busy", out_code, 13);
    wait_idle();
    check(out_code == 7, "R7 update at completion after pulse", out_code, 7);
    ldac_n = 0;
    @(negedge clk);

    // R1 sweep: every data and gain pair, offset varied
    for (int d = 0; d < FULL; d++) begin
      for (int g = 0; g < FULL; g++) begin
        int o, e;
        o = (d * 7 + g * 3) % FULL;
        e = model(d, g, o);
        calc(d, g, o);
        check(out_code == W'(e), "R1 sweep", out_code, e);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule